// File: doc/BRIEF.md
# Bridge Drive Sequencer with Latched Fault Supervision

This block is the digital control core of a two-channel bridge-tied-load switching output stage. Each channel takes a pair of pulse-width levels, one for the positive output node and one for the negative node. The block turns every level into gate enables for the high-side and low-side switches of one half bridge, so the four half bridges are driven from four levels. Every asynchronous input first passes through a flop synchronizer. Every level is then held for at least a minimum time, and every switch-over between high and low is separated by a programmable off interval.

Two active-low control inputs gate the stage. A shutdown input turns everything off. A mute input must also be high before any switch conducts. Digitized sense flags report die temperature against three thresholds, peak overcurrent, and undervoltage on the power rail and on the logic rail. A severe fault turns all switches off and is held in a latched error flag. The latch is released only by taking mute low and then high again once the cause has gone. A separate thermal warning flag follows the temperature with hysteresis and does not stop operation. There is no streaming data path: pulse-width inputs are plain levels sampled every clock, so no valid/ready handshake and no back-pressure apply.

Top module: `btl_stage_ctrl`

## Requirements
- R1: When the synchronized mute input is low, every `hs_en` and `ls_en` bit is 0 no later than the third rising clock edge after `mute_n` falls, and stays 0 while mute is low.
- R2: With mute and shutdown both high and no fault, half bridge 2c follows `pwm_p[c]` and half bridge 2c+1 follows `pwm_n[c]`. A level of 1 turns on that bridge's high-side enable and a level of 0 turns on its low-side enable. Both levels low therefore pulls both nodes to ground, and opposite levels give either output polarity.
- R3: Both levels of a channel high is a defined code: both high-side enables of that channel are on and both low-side enables are off.
- R4: While `shdn_n` is low, every enable is 0. Raising `shdn_n` with `mute_n` still low keeps every enable at 0; switching resumes only once mute is also high.
- R5: Any of `temp_trip`, `over_cur`, `uv_power` or `uv_logic` going high drives `err_n` low and every enable to 0 by the third rising edge after the input changes. Both stay that way after the cause has gone.
- R6: A latched error is cleared only by a low-to-high mute toggle made while no fault input is active. A mute rise during an active fault leaves the error latched.
- R7: `warn_n` goes low while `temp_warn` is high. It stays low while `temp_rel` (the release threshold) is high, and returns high once `temp_rel` is low. The warning does not alter the enables.
- R8: When a half bridge changes between high-side and low-side, both of its enables are 0 for exactly `dead_cyc`+1 clock cycles, and the two enables are never 1 together.
- R9: Each pulse-width level is held for at least `MIN_PULSE_CYC` cycles. An input pulse of W cycles produces an effective level of max(W, `MIN_PULSE_CYC`) cycles, so the enable pulse lasts that width less `dead_cyc`+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dead_cyc | input | DT_W | Off interval length minus one, in clocks (static configuration) |
| pwm_p | input | N_CH | Positive-node pulse-width level per channel (asynchronous) |
| pwm_n | input | N_CH | Negative-node pulse-width level per channel (asynchronous) |
| mute_n | input | 1 | Active-low mute; also the error-clear toggle |
| shdn_n | input | 1 | Active-low shutdown |
| temp_warn | input | 1 | Die temperature at or above the warning threshold |
| temp_rel | input | 1 | Die temperature above the warning release threshold |
| temp_trip | input | 1 | Die temperature above the shutdown threshold |
| over_cur | input | 1 | Peak output current at or above the limit |
| uv_power | input | 1 | Power rail below its operating threshold |
| uv_logic | input | 1 | Logic rail below its operating threshold |
| hs_en | output | 2*N_CH | High-side gate enable per half bridge |
| ls_en | output | 2*N_CH | Low-side gate enable per half bridge |
| warn_n | output | 1 | Active-low thermal warning |
| err_n | output | 1 | Active-low latched error |

## Verification
The bench checks the error latch against each fault source, and shows that a mute toggle made while the fault persists does not clear it. A design that cleared on any mute edge, or on the fault simply going away, would release the outputs into a live short. It counts the off interval at a high-to-low switch-over, where an off-by-one count or a missing gap would mean shoot-through. It also checks that a one-cycle input pulse is stretched to the minimum width rather than passed or lost. The warning hysteresis is checked from both sides: a flag that dropped at the set threshold, or that gated the outputs, would be reported.

// File: rtl/btl_pkg.sv
package btl_pkg;
  // Drive state applied to one half bridge.
  typedef enum logic [1:0] {
    LEG_OFF  = 2'd0,
    LEG_HIGH = 2'd1,
    LEG_LOW  = 2'd2
  } leg_t;

  // Number of non-pwm asynchronous inputs carried through the synchronizer.
  localparam int unsigned CTRL_BITS = 8;
endpackage

// File: rtl/btl_sync.sv
module btl_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/btl_pulse_guard.sv
module btl_pulse_guard #(
  parameter int unsigned MIN_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic lvl_o
);
  localparam int unsigned HOLD_W = (MIN_CYC > 2) ? $clog2(MIN_CYC) : 1;

  logic              lvl_q;
  logic [HOLD_W-1:0] hold_q;

  // A new level is taken only once the previous one has lasted MIN_CYC cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      hold_q <= '0;
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
    end else if (lvl_i != lvl_q) begin
      lvl_q  <= lvl_i;
      hold_q <= HOLD_W'(MIN_CYC - 1);
    end
  end

  assign lvl_o = lvl_q;

  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q != '0) |=> $stable(lvl_q)); // R9
endmodule

// File: rtl/btl_leg_drv.sv
module btl_leg_drv
  import btl_pkg::*;
#(
  parameter int unsigned DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DT_W-1:0] dead_cyc,
  input  leg_t            tgt_i,
  output logic            hs_o,
  output logic            ls_o
);
  leg_t            drv_q;
  logic [DT_W-1:0] cnt_q;

  // Any change first drops to OFF; a switch turns on only after the gap expires.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= LEG_OFF;
      cnt_q <= '0;
    end else if (tgt_i != drv_q) begin
      if (drv_q != LEG_OFF) begin
        drv_q <= LEG_OFF;
        cnt_q <= dead_cyc;
      end else if (cnt_q == '0) begin
        drv_q <= tgt_i;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign hs_o = (drv_q == LEG_HIGH);
  assign ls_o = (drv_q == LEG_LOW);

  AST_HS_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_o) |-> !$past(ls_o)); // R8
  AST_LS_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_o) |-> !$past(hs_o)); // R8
endmodule

// File: rtl/btl_fault_sup.sv
module btl_fault_sup (
  input  logic clk,
  input  logic rst_n,
  input  logic mute_s,
  input  logic t_warn_s,
  input  logic t_rel_s,
  input  logic t_trip_s,
  input  logic oc_s,
  input  logic uv_pwr_s,
  input  logic uv_log_s,
  output logic fault_now_o,
  output logic err_o,
  output logic warn_o
);
  logic mute_prev_q;
  logic err_q;
  logic warn_q;
  logic mute_rise;

  assign fault_now_o = t_trip_s | oc_s | uv_pwr_s | uv_log_s;
  assign mute_rise   = mute_s & ~mute_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_prev_q <= 1'b0;
      err_q       <= 1'b0;
      warn_q      <= 1'b0;
    end else begin
      mute_prev_q <= mute_s;
      if (fault_now_o)    err_q <= 1'b1;
      else if (mute_rise) err_q <= 1'b0;
      if (t_warn_s)       warn_q <= 1'b1;
      else if (!t_rel_s)  warn_q <= 1'b0;
    end
  end

  assign err_o  = err_q;
  assign warn_o = warn_q;

  AST_ERR_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !mute_rise) |=> err_q); // R5
  AST_ERR_NO_CLEAR_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_now_o |=> err_q); // R6
  AST_WARN_HYST: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_q && t_rel_s) |=> warn_q); // R7
endmodule

// File: rtl/btl_stage_ctrl.sv
module btl_stage_ctrl
  import btl_pkg::*;
#(
  parameter int unsigned N_CH          = 2,
  parameter int unsigned DT_W          = 4,
  parameter int unsigned MIN_PULSE_CYC = 10,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DT_W-1:0]   dead_cyc,
  input  logic [N_CH-1:0]   pwm_p,
  input  logic [N_CH-1:0]   pwm_n,
  input  logic              mute_n,
  input  logic              shdn_n,
  input  logic              temp_warn,
  input  logic              temp_rel,
  input  logic              temp_trip,
  input  logic              over_cur,
  input  logic              uv_power,
  input  logic              uv_logic,
  output logic [2*N_CH-1:0] hs_en,
  output logic [2*N_CH-1:0] ls_en,
  output logic              warn_n,
  output logic              err_n
);
  localparam int unsigned N_LEG  = 2 * N_CH;
  localparam int unsigned SYNC_W = N_LEG + CTRL_BITS;
  localparam int unsigned IX_MUTE = N_LEG;
  localparam int unsigned IX_SHDN = N_LEG + 1;
  localparam int unsigned IX_TWRN = N_LEG + 2;
  localparam int unsigned IX_TREL = N_LEG + 3;
  localparam int unsigned IX_TTRP = N_LEG + 4;
  localparam int unsigned IX_OC   = N_LEG + 5;
  localparam int unsigned IX_UVP  = N_LEG + 6;
  localparam int unsigned IX_UVL  = N_LEG + 7;

  logic [SYNC_W-1:0] raw, syn;
  logic [N_LEG-1:0]  leg_raw;
  logic [N_LEG-1:0]  leg_lvl;
  logic              fault_now, err_q, warn_q, enable;
  leg_t              tgt [N_LEG];

  // Interleave levels so that leg 2c is the plus node and 2c+1 the minus node.
  for (genvar c = 0; c < N_CH; c++) begin : g_pair
    assign leg_raw[2*c]   = pwm_p[c];
    assign leg_raw[2*c+1] = pwm_n[c];
  end

  assign raw = {uv_logic, uv_power, over_cur, temp_trip,
                temp_rel, temp_warn, shdn_n, mute_n, leg_raw};

  btl_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw),
    .q_o  (syn)
  );

  btl_fault_sup u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .mute_s     (syn[IX_MUTE]),
    .t_warn_s   (syn[IX_TWRN]),
    .t_rel_s    (syn[IX_TREL]),
    .t_trip_s   (syn[IX_TTRP]),
    .oc_s       (syn[IX_OC]),
    .uv_pwr_s   (syn[IX_UVP]),
    .uv_log_s   (syn[IX_UVL]),
    .fault_now_o(fault_now),
    .err_o      (err_q),
    .warn_o     (warn_q)
  );

  assign enable = syn[IX_MUTE] & syn[IX_SHDN] & ~err_q & ~fault_now;

  for (genvar l = 0; l < N_LEG; l++) begin : g_leg
    btl_pulse_guard #(.MIN_CYC(MIN_PULSE_CYC)) u_guard (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl_i(syn[l]),
      .lvl_o(leg_lvl[l])
    );

    assign tgt[l] = !enable     ? LEG_OFF  :
                    leg_lvl[l]  ? LEG_HIGH : LEG_LOW;

    btl_leg_drv #(.DT_W(DT_W)) u_drv (
      .clk     (clk),
      .rst_n   (rst_n),
      .dead_cyc(dead_cyc),
      .tgt_i   (tgt[l]),
      .hs_o    (hs_en[l]),
      .ls_o    (ls_en[l])
    );
  end

  assign err_n  = ~err_q;
  assign warn_n = ~warn_q;

  AST_MUTE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    !syn[IX_MUTE] |=> (hs_en == '0 && ls_en == '0)); // R1
  AST_SHDN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    !syn[IX_SHDN] |=> (hs_en == '0 && ls_en == '0)); // R4
  AST_ERR_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    !err_n |-> (hs_en == '0 && ls_en == '0)); // R5
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en & ls_en) == '0); // R8
endmodule

// File: tb/btl_stage_ctrl_test.sv
`timescale 1ns/1ps
module btl_stage_ctrl_test;
  localparam int N_CH = 2;
  localparam int MINP = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] dead = 4'd1;
  logic [1:0] pp = '0, pn = '0;
  logic       mute_n = 1'b0, shdn_n = 1'b0;
  logic       t_warn = 0, t_rel = 0, t_trip = 0, oc = 0, uvp = 0, uvl = 0;
  logic [3:0] hs_en, ls_en;
  logic       warn_n, err_n;
  int         tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  btl_stage_ctrl #(.N_CH(N_CH), .DT_W(4), .MIN_PULSE_CYC(MINP), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .dead_cyc(dead), .pwm_p(pp), .pwm_n(pn),
    .mute_n(mute_n), .shdn_n(shdn_n), .temp_warn(t_warn), .temp_rel(t_rel),
    .temp_trip(t_trip), .over_cur(oc), .uv_power(uvp), .uv_logic(uvl),
    .hs_en(hs_en), .ls_en(ls_en), .warn_n(warn_n), .err_n(err_n));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] legs(input logic [1:0] p, input logic [1:0] n);
    logic [3:0] h;
    for (int c = 0; c < N_CH; c++) begin
      h[2*c]   = p[c];
      h[2*c+1] = n[c];
    end
    return {h, ~h};
  endfunction

  task automatic t_reset;
    check("R1 reset enables", {hs_en, ls_en}, 8'h00);
    check("R5 reset err_n", err_n, 1);
    check("R7 reset warn_n", warn_n, 1);
  endtask

  task automatic t_decode;
    mute_n = 1; shdn_n = 1; dead = 4'd1;
    for (int k = 0; k < 16; k++) begin
      pp = k[1:0]; pn = k[3:2];
      step(30);
      if (pp[0] && pn[0]) check("R3 both high ch0", {hs_en[1:0], ls_en[1:0]}, 4'b1100);
      else check("R2 decode ch0", {hs_en[1:0], ls_en[1:0]},
                 {legs(pp, pn)[5:4], legs(pp, pn)[1:0]});
      check("R2 decode all legs", {hs_en, ls_en}, legs(pp, pn));
    end
  endtask

  task automatic t_mute;
    pp = 2'b01; pn = 2'b10; step(30);
    check("R1 driving before mute", {hs_en, ls_en}, legs(pp, pn));
    mute_n = 0; step(3);
    check("R1 off by third edge", {hs_en, ls_en}, 8'h00);
    pp = 2'b11; step(20);
    check("R1 stays off while muted", {hs_en, ls_en}, 8'h00);
    mute_n = 1; step(30);
    check("R1 resumes on unmute", {hs_en, ls_en}, legs(pp, pn));
  endtask

  task automatic t_shutdown;
    shdn_n = 0; step(4);
    check("R4 shutdown off", {hs_en, ls_en}, 8'h00);
    mute_n = 0; step(5); shdn_n = 1; step(20);
    check("R4 shutdown release with mute low", {hs_en, ls_en}, 8'h00);
    mute_n = 1; step(30);
    check("R4 on after mute high", {hs_en, ls_en}, legs(pp, pn));
  endtask

  task automatic t_dead;
    int gap, both;
    dead = 4'd3; pp = 2'b01; pn = 2'b00; step(30);
    gap = 0; both = 0;
    pp[0] = 0;
    for (int i = 0; i < 30; i++) begin
      step(1);
      if (!hs_en[0] && !ls_en[0]) gap++;
      if (hs_en[0] && ls_en[0]) both++;
    end
    check("R8 off gap cycles", gap, 4);
    check("R8 no overlap", both, 0);
    check("R8 low side after gap", ls_en[0], 1);
  endtask

  task automatic t_pulse(input int width, input int exp_hi);
    int hi;
    dead = 4'd0; pp = 2'b00; pn = 2'b00; step(30);
    hi = 0;
    pp[0] = 1;
    for (int i = 0; i < width + 40; i++) begin
      if (i == width) pp[0] = 0;
      step(1);
      if (hs_en[0]) hi++;
    end
    check("R9 stretched pulse width", hi, exp_hi);
  endtask

  task automatic set_fault(input int src, input logic v);
    case (src)
      0: t_trip = v;
      1: oc = v;
      2: uvp = v;
      default: uvl = v;
    endcase
  endtask

  task automatic t_faults;
    dead = 4'd1; pp = 2'b10; pn = 2'b01;
    for (int s = 0; s < 4; s++) begin
      step(30);
      check("R5 driving before fault", {hs_en, ls_en}, legs(pp, pn));
      set_fault(s, 1); step(3);
      check("R5 err_n low", err_n, 0);
      check("R5 bridges off", {hs_en, ls_en}, 8'h00);
      set_fault(s, 0); step(20);
      check("R5 still latched", err_n, 0);
      check("R5 still off", {hs_en, ls_en}, 8'h00);
      mute_n = 0; step(5); mute_n = 1; step(30);
      check("R6 cleared by toggle", err_n, 1);
      check("R6 drive restored", {hs_en, ls_en}, legs(pp, pn));
    end
  endtask

  task automatic t_clear_blocked;
    oc = 1; step(5);
    mute_n = 0; step(5); mute_n = 1; step(10);
    check("R6 toggle during fault keeps err", err_n, 0);
    oc = 0; step(20);
    check("R6 fault gone no toggle", err_n, 0);
    check("R6 still off", {hs_en, ls_en}, 8'h00);
    mute_n = 0; step(5); mute_n = 1; step(30);
    check("R6 clear after cause gone", err_n, 1);
  endtask

  task automatic t_warning;
    t_warn = 1; t_rel = 1; step(4);
    check("R7 warn set", warn_n, 0);
    check("R7 drive unaffected", {hs_en, ls_en}, legs(pp, pn));
    check("R7 no error", err_n, 1);
    t_warn = 0; step(10);
    check("R7 held above release", warn_n, 0);
    t_rel = 0; step(4);
    check("R7 released", warn_n, 1);
  endtask

  initial begin
    step(3); rst_n = 1; step(5);
    t_reset();
    t_decode();
    t_mute();
    t_shutdown();
    t_dead();
    t_pulse(1, MINP - 1);
    t_pulse(25, 24);
    t_faults();
    t_clear_blocked();
    t_warning();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule